// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Driver

This block turns a serial bit stream into a 32-wide parallel vector of output switch controls. Bits are taken from the serial input on each falling clock edge and move through a 32-stage register. A level-sensitive latch bank copies the register while the latch enable is high and freezes it while the enable is low. The outputs follow the latched bits, but two gating controls come between the latch and the outputs. The blank control, which is active low, and the polarity control together can force every output on, force every output off, invert the latched pattern or pass it straight through. In `drv_on`, a 1 means the output is sinking (on).

The last register stage always appears on a serial output, so several blocks can be chained: the serial output of one feeds the serial input of the next, and all of them share the clock and controls. A compile-time parameter sets which way data moves along the output order. Index 0 of `drv_on` is the first output.

Top module: `spd_driver`

## Requirements
- R1: The register has `N` = 32 stages. `sdo` shows the last stage. With `SHIFT_UP`=1 that is index N-1, and a bit applied to `sdi` appears on `sdo` after N falling edges.
- R2: On each falling clock edge that is not a reset edge, every stage takes its neighbour's value and the first stage takes `sdi`. `le`, `blank_n` and `pol` have no effect on this.
- R3: While `le` is 1 the latch bank equals the register contents. While `le` is 0 it holds its value, even as the register keeps shifting.
- R4: `blank_n`=0 with `pol`=0 drives every bit of `drv_on` to 1.
- R5: `blank_n`=0 with `pol`=1 drives every bit of `drv_on` to 0.
- R6: `blank_n`=1 with `pol`=0 drives each `drv_on` bit to the inverse of its latch bit.
- R7: `blank_n`=1 with `pol`=1 drives each `drv_on` bit equal to its latch bit.
- R8: With `SHIFT_UP`=1, data enters at index 0 and moves toward index N-1. With `SHIFT_UP`=0, it enters at index N-1, moves toward index 0, and `sdo` is index 0. After N edges, the first bit shifted in sits at index N-1 or at index 0 respectively.
- R9: `rst` high at a falling clock edge clears the register to 0. While `rst` is high the latch bank is held at 0.
- R10: In a chain of two blocks (the upstream `sdo` drives the downstream `sdi`), after 2N falling edges and one latch pulse the downstream outputs show the first N bits shifted in and the upstream outputs show the last N bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the register advances on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| sdi | input | 1 | Serial data input |
| le | input | 1 | Latch enable: 1 transparent, 0 hold |
| blank_n | input | 1 | Blanking control, active low |
| pol | input | 1 | Polarity control |
| sdo | output | 1 | Serial data output (last register stage) for chaining |
| drv_on | output | N | Output switch controls, 1 = on |

## Verification
The bound checker checks on every falling edge that each stage takes its neighbour's value in the configured direction, whatever the control inputs are. It also checks that the serial output follows the stage before it, that the latch equals the register while enabled, that reset leaves everything at zero, and the four gating relations between the latch and the outputs. Some behaviours only the bench scenarios can show. One is that the latch keeps a pattern while many bits pass through the register. Another is the placement of whole patterns for both shift directions. A third is the two-block chain, where 64 bits loaded and latched must land split between the two output vectors.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Output gating mode, encoded as {blank_n, pol}
  typedef enum logic [1:0] {
    GATE_ALL_ON  = 2'b00,
    GATE_ALL_OFF = 2'b01,
    GATE_INVERT  = 2'b10,
    GATE_DIRECT  = 2'b11
  } gate_mode_e;
endpackage

// File: rtl/spd_shift_reg.sv
module spd_shift_reg #(
  parameter int N        = 32,
  parameter bit SHIFT_UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  output logic [N-1:0] sr_q,
  output logic         sdo
);
  localparam int LAST = SHIFT_UP ? N - 1 : 0;

  generate
    if (SHIFT_UP) begin : g_up
      // entry at index 0, exit at index N-1
      always_ff @(negedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[N-2:0], sdi};
      end
    end else begin : g_down
      // entry at index N-1, exit at index 0
      always_ff @(negedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sdi, sr_q[N-1:1]};
      end
    end
  endgenerate

  assign sdo = sr_q[LAST];
endmodule

// File: rtl/spd_latch_bank.sv
module spd_latch_bank #(
  parameter int N = 32
) (
  input  logic         rst,
  input  logic         le,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // Level-sensitive storage: follows d while le is high, holds when low.
  always_latch begin
    if (rst)     q = '0;
    else if (le) q = d;
  end
endmodule

// File: rtl/spd_out_gate.sv
module spd_out_gate
  import spd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         blank_n,
  input  logic         pol,
  input  logic [N-1:0] lat,
  output logic [N-1:0] drv_on
);
  gate_mode_e mode;

  always_comb begin
    mode = gate_mode_e'({blank_n, pol});
    unique case (mode)
      GATE_ALL_ON:  drv_on = '1;
      GATE_ALL_OFF: drv_on = '0;
      GATE_INVERT:  drv_on = ~lat;
      default:      drv_on = lat;
    endcase
  end
endmodule

// File: rtl/spd_driver.sv
module spd_driver #(
  parameter int N        = 32,
  parameter bit SHIFT_UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic         le,
  input  logic         blank_n,
  input  logic         pol,
  output logic         sdo,
  output logic [N-1:0] drv_on
);
  logic [N-1:0] sr_q;
  logic [N-1:0] hold_q;

  spd_shift_reg #(.N(N), .SHIFT_UP(SHIFT_UP)) u_sr (
    .clk (clk),
    .rst (rst),
    .sdi (sdi),
    .sr_q(sr_q),
    .sdo (sdo)
  );

  spd_latch_bank #(.N(N)) u_lat (
    .rst(rst),
    .le (le),
    .d  (sr_q),
    .q  (hold_q)
  );

  spd_out_gate #(.N(N)) u_gate (
    .blank_n(blank_n),
    .pol    (pol),
    .lat    (hold_q),
    .drv_on (drv_on)
  );
endmodule

// File: rtl/spd_driver_chk.sv
module spd_driver_chk #(
  parameter int N        = 32,
  parameter bit SHIFT_UP = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         sdi,
  input logic         le,
  input logic         blank_n,
  input logic         pol,
  input logic         sdo,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] hold_q,
  input logic [N-1:0] drv_on
);
  generate
    if (SHIFT_UP) begin : g_up
      // R2 R8
      shift_up_chk: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> (sr_q == {$past(sr_q[N-2:0]), $past(sdi)}));
      // R1
      sdo_up_chk: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> (sdo == $past(sr_q[N-2])));
    end else begin : g_down
      // R2 R8
      shift_down_chk: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> (sr_q == {$past(sdi), $past(sr_q[N-1:1])}));
      // R1
      sdo_down_chk: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> (sdo == $past(sr_q[1])));
    end
  endgenerate

  // R3
  latch_follow_chk: assert property (@(negedge clk) disable iff (rst)
    le |-> (hold_q == sr_q));
  // R9
  reset_clear_chk: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (sr_q == '0 && hold_q == '0));
  // R4
  all_on_chk: assert property (@(negedge clk) disable iff (rst)
    (!blank_n && !pol) |-> (&drv_on));
  // R5
  all_off_chk: assert property (@(negedge clk) disable iff (rst)
    (!blank_n && pol) |-> (drv_on == '0));
  // R6
  invert_chk: assert property (@(negedge clk) disable iff (rst)
    (blank_n && !pol) |-> (drv_on == ~hold_q));
  // R7
  direct_chk: assert property (@(negedge clk) disable iff (rst)
    (blank_n && pol) |-> (drv_on == hold_q));
endmodule

bind spd_driver spd_driver_chk #(.N(N), .SHIFT_UP(SHIFT_UP)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sdi    (sdi),
  .le     (le),
  .blank_n(blank_n),
  .pol    (pol),
  .sdo    (sdo),
  .sr_q   (sr_q),
  .hold_q (hold_q),
  .drv_on (drv_on)
);

// File: tb/spd_driver_tb.sv
module spd_driver_tb;
  localparam int N = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;            // 50 MHz
  logic run = 1'b1;                 // clock gate, changed only while clk is high
  wire  dclk = clk | ~run;

  logic rst = 1'b1, sdi = 1'b0, le = 1'b0, blank_n = 1'b1, pol = 1'b1;
  logic sdo_a, sdo_b, sdo_r;
  logic [N-1:0] drv_a, drv_b, drv_r;

  // upstream (shift up), chained downstream, and a reverse-direction copy
  spd_driver #(.N(N), .SHIFT_UP(1'b1)) u_dut (
    .clk(dclk), .rst(rst), .sdi(sdi), .le(le), .blank_n(blank_n), .pol(pol),
    .sdo(sdo_a), .drv_on(drv_a));
  spd_driver #(.N(N), .SHIFT_UP(1'b1)) u_chain (
    .clk(dclk), .rst(rst), .sdi(sdo_a), .le(le), .blank_n(blank_n), .pol(pol),
    .sdo(sdo_b), .drv_on(drv_b));
  spd_driver #(.N(N), .SHIFT_UP(1'b0)) u_rev (
    .clk(dclk), .rst(rst), .sdi(sdi), .le(le), .blank_n(blank_n), .pol(pol),
    .sdo(sdo_r), .drv_on(drv_r));

  int nchk = 0, nfail = 0;
  bit hist[$];                      // bits shifted since last reset, newest at back
  logic [N-1:0] m_hold_a = '0, m_hold_b = '0, m_hold_r = '0;

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit age(int k);
    if (k < hist.size()) return hist[hist.size() - 1 - k];
    return 1'b0;
  endfunction

  // kind 0 upstream, 1 chained, 2 reverse
  function automatic logic [N-1:0] reg_model(int kind);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (kind == 0) ? age(i) : (kind == 1) ? age(N + i) : age(N - 1 - i);
    return v;
  endfunction

  function automatic logic [N-1:0] gate_model(logic [N-1:0] lat);
    case ({blank_n, pol})
      2'b00:   return '1;
      2'b01:   return '0;
      2'b10:   return ~lat;
      default: return lat;
    endcase
  endfunction

  function automatic string mode_tag();
    case ({blank_n, pol})
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [N-1:0] rev_bits(logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[N - 1 - i];
    return r;
  endfunction

  // one clock period: drive at rising edge, model and compare after falling edge
  task automatic step(input bit d, input bit l, input bit b, input bit p, input bit r, input bit en);
    logic [N-1:0] ea, eb, er;
    @(posedge clk);
    sdi = d; le = l; blank_n = b; pol = p; rst = r; run = en;
    @(negedge clk);
    #1;
    if (en) begin
      if (r) hist.delete();
      else begin
        hist.push_back(d);
        if (hist.size() > 2 * N + 4) void'(hist.pop_front());
      end
    end
    if (r) begin
      m_hold_a = '0; m_hold_b = '0; m_hold_r = '0;
    end else if (l) begin
      m_hold_a = reg_model(0); m_hold_b = reg_model(1); m_hold_r = reg_model(2);
    end
    ea = gate_model(m_hold_a); eb = gate_model(m_hold_b); er = gate_model(m_hold_r);
    check(sdo_a == age(N - 1), "R1 R2 sdo", {{(N-1){1'b0}}, sdo_a}, {{(N-1){1'b0}}, age(N - 1)});
    check(drv_a == ea, mode_tag(), drv_a, ea);
    check(drv_r == er, "R8 reverse", drv_r, er);
    check(drv_b == eb, "R10 chain", drv_b, eb);
    check(sdo_b == age(2 * N - 1), "R10 chain sdo", {{(N-1){1'b0}}, sdo_b}, {{(N-1){1'b0}}, age(2 * N - 1)});
  endtask

  task automatic load(input logic [N-1:0] pat);
    for (int i = N - 1; i >= 0; i--) step(pat[i], 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [N-1:0] PAT_A = 32'hA5C3_1E7F;
  localparam logic [N-1:0] PAT_B = 32'h1234_F00D;
  localparam logic [N-1:0] PAT_C = 32'hC0DE_8421;

  initial begin
    logic [7:0] lfsr;
    // R9: reset clears register and latches
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check(drv_a == '0 && sdo_a == 1'b0, "R9 reset state", drv_a, '0);

    // R3: loading with latch closed leaves outputs at zero
    load(PAT_A);
    check(drv_a == '0, "R3 hold during load", drv_a, '0);

    // latch pulse with the clock stopped
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check(drv_a == PAT_A, "R7 direct pattern", drv_a, PAT_A);
    check(drv_r == rev_bits(PAT_A), "R8 reverse placement", drv_r, rev_bits(PAT_A));

    // gating modes with the clock stopped
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(drv_a == '1, "R4 all on", drv_a, '1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(drv_a == '0, "R5 all off", drv_a, '0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(drv_a == ~PAT_A, "R6 invert", drv_a, ~PAT_A);

    // R3: register keeps shifting, latch keeps PAT_A
    for (int i = 0; i < 8; i++) step(i[0], 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check(drv_a == PAT_A, "R3 latch holds while shifting", drv_a, PAT_A);

    // R2: shifting under varying controls, compared every cycle
    lfsr = 8'h5B;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3], 1'b0, 1'b1);
    end

    // R9: reset while latch is open
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check(drv_a == '0 && drv_b == '0 && drv_r == '0, "R9 mid-run reset", drv_a | drv_b | drv_r, '0);

    // R10: 64 bits into the two-block chain, then one latch pulse
    load(PAT_B);
    load(PAT_C);
    check(sdo_a == PAT_C[N-1], "R1 sdo last stage", {{(N-1){1'b0}}, sdo_a}, {{(N-1){1'b0}}, PAT_C[N-1]});
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check(drv_a == PAT_C, "R10 upstream pattern", drv_a, PAT_C);
    check(drv_b == PAT_B, "R10 downstream pattern", drv_b, PAT_B);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

    finish_run();
  end
endmodule